// File: doc/BRIEF.md
# In-band ECC check-code line manager

This block sits between a memory client and a burst-oriented external memory port. The client reads and writes 64-byte data blocks. Each block has a 16-bit check code, and the codes are stored in the same memory as the data, in a reserved region at the top of the address space. For every client access the block forwards the data transfer to memory and finds the code slot that belongs to the block. A write stores the new code in that slot. A read returns the stored code with the data, so the caller can check integrity. Computing and checking the codes is done elsewhere; the codes enter and leave on plain ports.

A small direct-mapped cache holds whole 64-byte lines of codes, 32 codes to a line. A line goes back to memory only as a full burst, and only when it is dirty. When a code must change in a line that is not cached, the line is first read from memory and the slot is then merged into it. A flush input writes every dirty line back in index order and raises a done pulse. The memory port carries one transaction at a time.

Top module: `ibecc_line_mgr`

## Requirements
- R1: The code of block b lives in the reserved line at address RSV_BASE + (b >> 5), in bits [s*16 +: 16] with s = b[4:0]. RSV_BASE = 2^ADDR_W - 2^(ADDR_W-5), so the reserved region is 1/32 of the space.
- R2: A client request with block address >= RSV_BASE gets a response with rsp_err=1 one cycle after it is accepted, and it causes no memory request.
- R3: A client write stores req_wdata at memory address req_blk. Its response has rsp_err=0 and rsp_code equal to the code that was written.
- R4: A client read response carries the block data and the block's current code in the same beat, with rsp_err=0.
- R5: Codes reach memory only as whole 512-bit lines, and a clean line is never written back. When a dirty victim must be evicted, the write order is: data write, then the victim write-back, then the refill read of the new line.
- R6: When a write misses the cache, the block reads the full line, replaces only the target slot and marks the line dirty. The other 31 slots keep their values from memory.
- R7: A flush_req pulse writes back every dirty entry in ascending cache index, where the index is (b >> 5) mod 4. flush_done is a one-cycle pulse after the last write-back is accepted.
- R8: A flush while no entry is dirty issues no memory write and still pulses flush_done.
- R9: At most one memory read is outstanding. No request is issued while a read response is pending.
- R10: A read whose code line is already cached issues exactly one memory access, the data read.
- R11: While mem_req_valid is high and mem_req_ready is low, the request stays asserted and its address, direction and data do not change.
- R12: After reset, req_ready=1, rsp_valid=0, mem_req_valid=0 and flush_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_blk | input | ADDR_W | Block address (64-byte units) |
| req_wdata | input | LINE_W | Write data block |
| req_code | input | CODE_W | Check code for a write |
| rsp_valid | output | 1 | One-cycle response beat |
| rsp_err | output | 1 | Request hit the reserved region |
| rsp_data | output | LINE_W | Read data (zero for writes) |
| rsp_code | output | CODE_W | Stored code (read) or written code (write) |
| flush_req | input | 1 | Start writing back all dirty lines |
| flush_done | output | 1 | Flush finished pulse |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_addr | output | ADDR_W | Memory address (64-byte units) |
| mem_req_wdata | output | LINE_W | Write burst data |
| mem_rsp_valid | input | 1 | Read burst data present |
| mem_rsp_data | input | LINE_W | Read burst data |

## Verification
The hardest situation to reach from the ports is the eviction of a dirty line at the moment a new code line must be fetched. Reaching it needs two writes whose code lines share a cache index, and it is only visible in the order of memory operations. The bench preloads the reserved memory with arithmetic codes and first sweeps reads over every block, which leaves clean lines in the cache. It then writes block 0 and block 128, which share index 0, logs the memory operations of the second write and checks their order. A write sweep over every third block then forces a dirty eviction on nearly every line. Reading the reserved lines back from the bench memory shows that the untouched slots kept their preloaded codes.

// File: rtl/ibecc_pkg.sv
package ibecc_pkg;

    localparam int unsigned IBE_LINE_W  = 512;
    localparam int unsigned IBE_CODE_W  = 16;
    localparam int unsigned IBE_ENTRIES = 4;
    localparam int unsigned IBE_ADDR_W  = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DATA_REQ,
        ST_DATA_WAIT,
        ST_LOOKUP,
        ST_WB_REQ,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_FL_SCAN,
        ST_FL_WB
    } seq_state_e;

    // First address of the reserved code region: top 2^(addr_w-slot_w) lines.
    function automatic longint unsigned rsv_base(input int unsigned addr_w,
                                                 input int unsigned slot_w);
        return (64'd1 << addr_w) - (64'd1 << (addr_w - slot_w));
    endfunction

endpackage

// File: rtl/ibecc_addr_map.sv
module ibecc_addr_map #(
    parameter int unsigned ADDR_W = ibecc_pkg::IBE_ADDR_W,
    parameter int unsigned SLOT_W = 5,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [ADDR_W-1:0]              blk,
    output logic [SLOT_W-1:0]              slot,
    output logic [IDX_W-1:0]               idx,
    output logic [ADDR_W-SLOT_W-IDX_W-1:0] tag,
    output logic [ADDR_W-1:0]              line_addr
);
    localparam int unsigned LIDX_W = ADDR_W - SLOT_W;
    localparam logic [ADDR_W-1:0] RSV_BASE = ADDR_W'(ibecc_pkg::rsv_base(ADDR_W, SLOT_W));

    logic [LIDX_W-1:0] line_idx;

    always_comb begin
        line_idx  = blk[ADDR_W-1:SLOT_W];
        slot      = blk[SLOT_W-1:0];
        idx       = line_idx[IDX_W-1:0];
        tag       = line_idx[LIDX_W-1:IDX_W];
        line_addr = RSV_BASE + ADDR_W'(line_idx);
    end
endmodule

// File: rtl/ibecc_line_cache.sv
module ibecc_line_cache #(
    parameter int unsigned LINE_W  = ibecc_pkg::IBE_LINE_W,
    parameter int unsigned CODE_W  = ibecc_pkg::IBE_CODE_W,
    parameter int unsigned ENTRIES = ibecc_pkg::IBE_ENTRIES,
    parameter int unsigned TAG_W   = 9
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(ENTRIES)-1:0]  idx,
    input  logic [$clog2(LINE_W/CODE_W)-1:0] slot,
    output logic                        rd_valid,
    output logic                        rd_dirty,
    output logic [TAG_W-1:0]            rd_tag,
    output logic [LINE_W-1:0]           rd_line,
    output logic [CODE_W-1:0]           rd_code,
    input  logic                        fill_en,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [LINE_W-1:0]           fill_line,
    input  logic                        slot_en,
    input  logic [CODE_W-1:0]           slot_code,
    input  logic                        clean_en
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic              valid_w [ENTRIES];
    logic              dirty_w [ENTRIES];
    logic [TAG_W-1:0]  tag_w   [ENTRIES];
    logic [LINE_W-1:0] line_w  [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic              valid_r;
        logic              dirty_r;
        logic [TAG_W-1:0]  tag_r;
        logic [LINE_W-1:0] line_r;
        logic              sel;

        assign sel = (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_r <= 1'b0;
                dirty_r <= 1'b0;
                tag_r   <= '0;
                line_r  <= '0;
            end else if (sel) begin
                if (fill_en) begin
                    valid_r <= 1'b1;
                    dirty_r <= 1'b0;
                    tag_r   <= fill_tag;
                    line_r  <= fill_line;
                end else if (slot_en) begin
                    dirty_r <= 1'b1;
                    line_r[slot*CODE_W +: CODE_W] <= slot_code;
                end else if (clean_en) begin
                    dirty_r <= 1'b0;
                end
            end
        end

        assign valid_w[i] = valid_r;
        assign dirty_w[i] = dirty_r;
        assign tag_w[i]   = tag_r;
        assign line_w[i]  = line_r;
    end

    always_comb begin
        rd_valid = valid_w[idx];
        rd_dirty = dirty_w[idx];
        rd_tag   = tag_w[idx];
        rd_line  = line_w[idx];
        rd_code  = rd_line[slot*CODE_W +: CODE_W];
    end
endmodule

// File: rtl/ibecc_seq.sv
module ibecc_seq #(
    parameter int unsigned ADDR_W  = ibecc_pkg::IBE_ADDR_W,
    parameter int unsigned LINE_W  = ibecc_pkg::IBE_LINE_W,
    parameter int unsigned CODE_W  = ibecc_pkg::IBE_CODE_W,
    parameter int unsigned ENTRIES = ibecc_pkg::IBE_ENTRIES,
    parameter int unsigned SLOT_W  = 5,
    parameter int unsigned IDX_W   = 2,
    parameter int unsigned TAG_W   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_blk,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic [CODE_W-1:0] req_code,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [LINE_W-1:0] rsp_data,
    output logic [CODE_W-1:0] rsp_code,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    output logic [ADDR_W-1:0] op_blk,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [TAG_W-1:0]  op_tag,
    input  logic [ADDR_W-1:0] op_line_addr,
    output logic [IDX_W-1:0]  cache_idx,
    input  logic              c_valid,
    input  logic              c_dirty,
    input  logic [TAG_W-1:0]  c_tag,
    input  logic [LINE_W-1:0] c_line,
    input  logic [CODE_W-1:0] c_code,
    output logic              fill_en,
    output logic              slot_en,
    output logic [CODE_W-1:0] slot_code,
    output logic              clean_en
);
    import ibecc_pkg::*;

    localparam logic [ADDR_W-1:0] RSV_BASE = ADDR_W'(rsv_base(ADDR_W, SLOT_W));
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);

    seq_state_e        state;
    logic              op_we;
    logic [LINE_W-1:0] op_wdata;
    logic [CODE_W-1:0] op_code;
    logic [LINE_W-1:0] data_buf;
    logic [IDX_W-1:0]  flush_idx;
    logic              hit;
    logic              flushing;
    logic [ADDR_W-1:0] victim_addr;

    always_comb begin
        flushing    = (state == ST_FL_SCAN) || (state == ST_FL_WB);
        cache_idx   = flushing ? flush_idx : op_idx;
        hit         = c_valid && (c_tag == op_tag);
        victim_addr = RSV_BASE + ADDR_W'({c_tag, cache_idx});

        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (state)
            ST_DATA_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = op_we;
                mem_req_addr  = op_blk;
                mem_req_wdata = op_wdata;
            end
            ST_WB_REQ, ST_FL_WB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = victim_addr;
                mem_req_wdata = c_line;
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = op_line_addr;
            end
            default: ;
        endcase

        req_ready = (state == ST_IDLE) && !flush_req;
        fill_en   = (state == ST_FILL_WAIT) && mem_rsp_valid;
        slot_en   = (state == ST_LOOKUP) && hit && op_we;
        slot_code = op_code;
        clean_en  = ((state == ST_WB_REQ) || (state == ST_FL_WB)) && mem_req_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            op_we      <= 1'b0;
            op_blk     <= '0;
            op_wdata   <= '0;
            op_code    <= '0;
            data_buf   <= '0;
            flush_idx  <= '0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_data   <= '0;
            rsp_code   <= '0;
            flush_done <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            flush_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (flush_req) begin
                        flush_idx <= '0;
                        state     <= ST_FL_SCAN;
                    end else if (req_valid) begin
                        if (req_blk >= RSV_BASE) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_data  <= '0;
                            rsp_code  <= '0;
                        end else begin
                            op_we    <= req_we;
                            op_blk   <= req_blk;
                            op_wdata <= req_wdata;
                            op_code  <= req_code;
                            state    <= ST_DATA_REQ;
                        end
                    end
                end
                ST_DATA_REQ: begin
                    if (mem_req_ready) state <= op_we ? ST_LOOKUP : ST_DATA_WAIT;
                end
                ST_DATA_WAIT: begin
                    if (mem_rsp_valid) begin
                        data_buf <= mem_rsp_data;
                        state    <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_data  <= op_we ? '0 : data_buf;
                        rsp_code  <= op_we ? op_code : c_code;
                        state     <= ST_IDLE;
                    end else if (c_valid && c_dirty) begin
                        state <= ST_WB_REQ;
                    end else begin
                        state <= ST_FILL_REQ;
                    end
                end
                ST_WB_REQ: begin
                    if (mem_req_ready) state <= ST_FILL_REQ;
                end
                ST_FILL_REQ: begin
                    if (mem_req_ready) state <= ST_FILL_WAIT;
                end
                ST_FILL_WAIT: begin
                    if (mem_rsp_valid) state <= ST_LOOKUP;
                end
                ST_FL_SCAN: begin
                    if (c_valid && c_dirty) begin
                        state <= ST_FL_WB;
                    end else if (flush_idx == LAST_IDX) begin
                        flush_done <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        flush_idx <= flush_idx + 1'b1;
                    end
                end
                ST_FL_WB: begin
                    if (mem_req_ready) begin
                        if (flush_idx == LAST_IDX) begin
                            flush_done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            flush_idx <= flush_idx + 1'b1;
                            state     <= ST_FL_SCAN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ibecc_line_mgr.sv
module ibecc_line_mgr #(
    parameter int unsigned ADDR_W  = ibecc_pkg::IBE_ADDR_W,
    parameter int unsigned LINE_W  = ibecc_pkg::IBE_LINE_W,
    parameter int unsigned CODE_W  = ibecc_pkg::IBE_CODE_W,
    parameter int unsigned ENTRIES = ibecc_pkg::IBE_ENTRIES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_blk,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic [CODE_W-1:0] req_code,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [LINE_W-1:0] rsp_data,
    output logic [CODE_W-1:0] rsp_code,
    input  logic              flush_req,
    output logic              flush_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data
);
    localparam int unsigned SLOT_W = $clog2(LINE_W / CODE_W);
    localparam int unsigned IDX_W  = $clog2(ENTRIES);
    localparam int unsigned TAG_W  = ADDR_W - SLOT_W - IDX_W;

    logic [ADDR_W-1:0] op_blk;
    logic [SLOT_W-1:0] op_slot;
    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic [ADDR_W-1:0] op_line_addr;
    logic [IDX_W-1:0]  cache_idx;
    logic              c_valid;
    logic              c_dirty;
    logic [TAG_W-1:0]  c_tag;
    logic [LINE_W-1:0] c_line;
    logic [CODE_W-1:0] c_code;
    logic              fill_en;
    logic              slot_en;
    logic [CODE_W-1:0] slot_code;
    logic              clean_en;

    ibecc_addr_map #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_map (
        .blk       (op_blk),
        .slot      (op_slot),
        .idx       (op_idx),
        .tag       (op_tag),
        .line_addr (op_line_addr)
    );

    ibecc_line_cache #(.LINE_W(LINE_W), .CODE_W(CODE_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cache (
        .clk       (clk),
        .rst       (rst),
        .idx       (cache_idx),
        .slot      (op_slot),
        .rd_valid  (c_valid),
        .rd_dirty  (c_dirty),
        .rd_tag    (c_tag),
        .rd_line   (c_line),
        .rd_code   (c_code),
        .fill_en   (fill_en),
        .fill_tag  (op_tag),
        .fill_line (mem_rsp_data),
        .slot_en   (slot_en),
        .slot_code (slot_code),
        .clean_en  (clean_en)
    );

    ibecc_seq #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CODE_W(CODE_W), .ENTRIES(ENTRIES),
        .SLOT_W(SLOT_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_we        (req_we),
        .req_blk       (req_blk),
        .req_wdata     (req_wdata),
        .req_code      (req_code),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_data      (rsp_data),
        .rsp_code      (rsp_code),
        .flush_req     (flush_req),
        .flush_done    (flush_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .op_blk        (op_blk),
        .op_idx        (op_idx),
        .op_tag        (op_tag),
        .op_line_addr  (op_line_addr),
        .cache_idx     (cache_idx),
        .c_valid       (c_valid),
        .c_dirty       (c_dirty),
        .c_tag         (c_tag),
        .c_line        (c_line),
        .c_code        (c_code),
        .fill_en       (fill_en),
        .slot_en       (slot_en),
        .slot_code     (slot_code),
        .clean_en      (clean_en)
    );
endmodule

// File: rtl/ibecc_line_mgr_chk.sv
module ibecc_line_mgr_chk #(
    parameter int unsigned ADDR_W = ibecc_pkg::IBE_ADDR_W,
    parameter int unsigned LINE_W = ibecc_pkg::IBE_LINE_W,
    parameter int unsigned CODE_W = ibecc_pkg::IBE_CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_blk,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              flush_done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [LINE_W-1:0] mem_req_wdata,
    input logic              mem_rsp_valid
);
    localparam int unsigned SLOT_W = $clog2(LINE_W / CODE_W);
    localparam logic [ADDR_W-1:0] RSV_BASE = ADDR_W'(ibecc_pkg::rsv_base(ADDR_W, SLOT_W));

    logic rd_pending;

    always_ff @(posedge clk) begin
        if (rst) rd_pending <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_pending <= 1'b1;
        else if (mem_rsp_valid) rd_pending <= 1'b0;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata))); // R11

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        rd_pending |-> !mem_req_valid); // R9

    AST_RSV_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_blk >= RSV_BASE)) |=> (rsp_valid && rsp_err)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done); // R7
endmodule

bind ibecc_line_mgr ibecc_line_mgr_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_ibecc_line_mgr.sv
`timescale 1ns/1ps
module sim_ibecc_line_mgr;
    localparam int AW    = 10;
    localparam int LW    = 512;
    localparam int CW    = 16;
    localparam int NBLK  = 1 << AW;
    localparam int BASE  = NBLK - (NBLK >> 5);
    localparam int NLINE = NBLK >> 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_blk = '0;
    logic [LW-1:0] req_wdata = '0;
    logic [CW-1:0] req_code = '0;
    logic          rsp_valid, rsp_err;
    logic [LW-1:0] rsp_data;
    logic [CW-1:0] rsp_code;
    logic          flush_req = 1'b0;
    logic          flush_done;
    logic          mem_req_valid, mem_req_we;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [LW-1:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    ibecc_line_mgr #(.ADDR_W(AW), .LINE_W(LW), .CODE_W(CW), .ENTRIES(4)) u0 (.*);

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [LW-1:0] mem [NBLK];
    logic [LW-1:0] data_ref [NBLK];
    logic [CW-1:0] code_ref [NBLK];

    function automatic logic [CW-1:0] init_code(int b);
        return CW'(b * 937) ^ 16'h5A5A;
    endfunction
    function automatic logic [CW-1:0] new_code(int b);
        return CW'(b * 613 + 17) ^ 16'hC3C3;
    endfunction
    function automatic logic [LW-1:0] data_pat(int b);
        return {16{(32'(b) * 32'h01000193) ^ 32'hDEAD0001}};
    endfunction
    function automatic logic [LW-1:0] exp_line(int l);
        logic [LW-1:0] v;
        for (int s = 0; s < 32; s++) v[s*CW +: CW] = code_ref[l*32 + s];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // memory model
    int rdy_cnt = 0;
    int rd_dly = 0;
    logic [AW-1:0] rd_addr = '0;
    int n_acc = 0;
    int n_rsv_wr = 0;
    int n_log = 0;
    logic          log_we [8];
    logic [AW-1:0] log_addr [8];
    int viol_out = 0;
    int viol_hold = 0;
    bit rd_pend = 1'b0;
    logic          p_stall = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic          p_we = 1'b0;
    logic [LW-1:0] p_wdata = '0;

    always @(posedge clk) begin
        rdy_cnt       <= (rdy_cnt == 2) ? 0 : rdy_cnt + 1;
        mem_req_ready <= (rdy_cnt != 0);
        mem_rsp_valid <= 1'b0;
        if (!rst) begin
            if (rd_pend && mem_req_valid) viol_out <= viol_out + 1;
            if (p_stall && !(mem_req_valid && mem_req_addr == p_addr && mem_req_we == p_we
                             && mem_req_wdata == p_wdata)) viol_hold <= viol_hold + 1;
            p_stall <= mem_req_valid && !mem_req_ready;
            p_addr  <= mem_req_addr;
            p_we    <= mem_req_we;
            p_wdata <= mem_req_wdata;
        end
        if (rd_dly != 0) begin
            rd_dly <= rd_dly - 1;
            if (rd_dly == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[rd_addr];
                rd_pend       <= 1'b0;
            end
        end
        if (!rst && mem_req_valid && mem_req_ready) begin
            n_acc <= n_acc + 1;
            if (n_log < 8) begin
                log_we[n_log]   <= mem_req_we;
                log_addr[n_log] <= mem_req_addr;
            end
            n_log <= n_log + 1;
            if (mem_req_we) begin
                mem[mem_req_addr] <= mem_req_wdata;
                if (int'(mem_req_addr) >= BASE) n_rsv_wr <= n_rsv_wr + 1;
            end else begin
                rd_addr <= mem_req_addr;
                rd_dly  <= 2;
                rd_pend <= 1'b1;
            end
        end
    end

    logic          r_err;
    logic [LW-1:0] r_data;
    logic [CW-1:0] r_code;
    bit            r_seen;

    task automatic do_req(input bit we, input int b, input logic [LW-1:0] wd, input logic [CW-1:0] cd);
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_blk = AW'(b); req_wdata = wd; req_code = cd;
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
        r_seen = rsp_valid; r_err = rsp_err; r_data = rsp_data; r_code = rsp_code;
        if (!r_seen) chk(1'b0, "response timeout", 0, 1);
    endtask

    bit done_seen;
    task automatic do_flush();
        int t;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        done_seen = flush_done;
        t = 0;
        while (!done_seen && t < 200) begin @(negedge clk); done_seen = flush_done; t++; end
        @(negedge clk);
    endtask

    initial begin
        int a0, w0;
        for (int b = 0; b < NBLK; b++) begin
            mem[b] = '0; data_ref[b] = '0; code_ref[b] = init_code(b);
        end
        for (int l = 0; l < NLINE; l++) mem[BASE + l] = exp_line(l);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12 req_ready", LW'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R12 rsp_valid", LW'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R12 mem_req_valid", LW'(mem_req_valid), 0);
        chk(flush_done == 1'b0, "R12 flush_done", LW'(flush_done), 0);

        // R4 / R1: read sweep over every client block
        for (int b = 0; b < BASE; b++) begin
            do_req(1'b0, b, '0, '0);
            chk(r_err == 1'b0 && r_code == code_ref[b], "R4 R1 read code", LW'(r_code), LW'(code_ref[b]));
            chk(r_data == data_ref[b], "R4 read data", r_data, data_ref[b]);
        end
        chk(n_rsv_wr == 0, "R5 clean lines not written", LW'(n_rsv_wr), 0);

        // R2 reserved requests
        a0 = n_acc;
        do_req(1'b0, BASE, '0, '0);
        chk(r_err == 1'b1, "R2 read reserved err", LW'(r_err), 1);
        do_req(1'b1, NBLK - 1, data_pat(7), 16'h1234);
        chk(r_err == 1'b1, "R2 write reserved err", LW'(r_err), 1);
        chk(n_acc == a0, "R2 no memory access", LW'(n_acc - a0), 0);
        chk(mem[NBLK-1] == exp_line(NLINE-1), "R2 reserved line untouched", mem[NBLK-1], exp_line(NLINE-1));

        // R5 ordering: blocks 0 and 128 share index 0
        do_req(1'b1, 0, data_pat(0), new_code(0));
        data_ref[0] = data_pat(0); code_ref[0] = new_code(0);
        chk(r_err == 1'b0 && r_code == new_code(0), "R3 write response", LW'(r_code), LW'(new_code(0)));
        n_log = 0;
        do_req(1'b1, 128, data_pat(128), new_code(128));
        data_ref[128] = data_pat(128); code_ref[128] = new_code(128);
        chk(n_log == 3, "R5 op count", LW'(n_log), 3);
        chk(log_we[0] == 1'b1 && log_addr[0] == AW'(128), "R5 first data write", LW'(log_addr[0]), 128);
        chk(log_we[1] == 1'b1 && log_addr[1] == AW'(BASE), "R5 victim writeback", LW'(log_addr[1]), LW'(BASE));
        chk(log_we[2] == 1'b0 && log_addr[2] == AW'(BASE + 4), "R5 refill read", LW'(log_addr[2]), LW'(BASE + 4));
        chk(mem[BASE] == exp_line(0), "R5 R6 evicted line content", mem[BASE], exp_line(0));

        // R3 / R6: write sweep over every third block
        for (int b = 0; b < BASE; b += 3) begin
            do_req(1'b1, b, data_pat(b), new_code(b));
            data_ref[b] = data_pat(b); code_ref[b] = new_code(b);
            chk(r_err == 1'b0 && r_code == new_code(b), "R3 write response", LW'(r_code), LW'(new_code(b)));
        end
        for (int l = 0; l < 27; l++)
            chk(mem[BASE + l] == exp_line(l), "R6 merged line before flush", mem[BASE + l], exp_line(l));

        // R10 hits in cached line 30
        a0 = n_acc;
        do_req(1'b0, 961, '0, '0);
        chk(n_acc - a0 == 1, "R10 single access on hit", LW'(n_acc - a0), 1);
        chk(r_code == code_ref[961] && r_data == data_ref[961], "R10 R4 hit code", LW'(r_code), LW'(code_ref[961]));
        a0 = n_acc;
        do_req(1'b0, 960, '0, '0);
        chk(n_acc - a0 == 1, "R10 single access on hit", LW'(n_acc - a0), 1);
        chk(r_code == code_ref[960] && r_data == data_ref[960], "R4 hit written code", LW'(r_code), LW'(code_ref[960]));

        // R7 flush: dirty lines 28,29,30,27 at indices 0..3
        n_log = 0; w0 = n_rsv_wr;
        do_flush();
        chk(done_seen, "R7 flush_done pulse", LW'(done_seen), 1);
        chk(n_log == 4 && n_rsv_wr - w0 == 4, "R7 writeback count", LW'(n_log), 4);
        chk(log_addr[0] == AW'(BASE + 28) && log_addr[1] == AW'(BASE + 29), "R7 order first", LW'(log_addr[0]), LW'(BASE + 28));
        chk(log_addr[2] == AW'(BASE + 30) && log_addr[3] == AW'(BASE + 27), "R7 order last", LW'(log_addr[3]), LW'(BASE + 27));
        chk(flush_done == 1'b0, "R7 done single cycle", LW'(flush_done), 0);

        // R8 flush with nothing dirty
        a0 = n_acc;
        do_flush();
        chk(done_seen, "R8 flush_done pulse", LW'(done_seen), 1);
        chk(n_acc == a0, "R8 no memory access", LW'(n_acc - a0), 0);

        // R1 whole reserved region and R3 data region
        for (int l = 0; l < NLINE; l++)
            chk(mem[BASE + l] == exp_line(l), "R1 reserved line after flush", mem[BASE + l], exp_line(l));
        for (int b = 0; b < BASE; b++)
            chk(mem[b] == data_ref[b], "R3 data in memory", mem[b], data_ref[b]);

        // R4 final read sweep
        for (int b = 0; b < BASE; b++) begin
            do_req(1'b0, b, '0, '0);
            chk(r_err == 1'b0 && r_code == code_ref[b], "R4 final read code", LW'(r_code), LW'(code_ref[b]));
            chk(r_data == data_ref[b], "R4 final read data", r_data, data_ref[b]);
        end

        chk(viol_out == 0, "R9 one outstanding read", LW'(viol_out), 0);
        chk(viol_hold == 0, "R11 request held while stalled", LW'(viol_hold), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule